// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is a single output cell of a programmable-logic fabric. It ORs a set of product terms into one sum term, can complement that sum, and passes the result through a storage element. The storage element is configured as a plain wire, an edge-triggered D or T flip-flop, or a level-sensitive transparent latch. The cell always returns its output to the interconnect on a feedback port. A pin-facing copy of the output and its enable are also driven. Configuration is static: it is only changed while reset is held.

The fabric clocks are modelled as level inputs (`gclk`) that are sampled by the system clock `clk`. One of them is picked per cell. An edge-triggered mode acts on the system cycle in which the picked level is first seen high. The result appears on the outputs one system cycle later. Latch mode is transparent in the same cycle the picked level is high.

A parameter selects the buried variant. A buried cell never drives a pin. It can instead act as an input register, whose data comes from the neighbouring pin with no polarity applied.

Top module: `mc_cell`

## Requirements
- R1: While `rst_n` is low, and after its release, the stored state is 0. In the D, T and latch modes `fb_out` reads 0 until the first trigger.
- R2: The sum term is the OR of all `pterm` bits, so it is 0 when no term is high. With `cfg_invert`=1 the complement of the sum term is used as the data.
- R3: With `cfg_mode`=0 (combinatorial), `fb_out` equals the data in the same system cycle.
- R4: With `cfg_mode`=1 (D), the state takes the data in the system cycle where the picked global clock is sampled high after being low. The state is visible on `fb_out` from the next cycle and holds otherwise.
- R5: With `cfg_mode`=2 (T), on such a rising edge the state inverts if the data is 1 and holds if the data is 0.
- R6: With `cfg_mode`=3 (latch), `fb_out` follows the data in every cycle the picked clock is high. While that clock is low, `fb_out` holds the last value that was passed through.
- R7: `cfg_clk_sel` picks `gclk[cfg_clk_sel]`. Activity on the other global clock has no effect on the state.
- R8: In a non-buried cell, `pin_oe` equals `cfg_pin_en`. `pin_out` equals the cell output while enabled and is 0 otherwise. `fb_out` carries the cell output whatever `cfg_pin_en` is.
- R9: In a buried cell, `pin_oe` and `pin_out` are always 0, and `fb_out` carries the cell output in every configuration.
- R10: In a buried cell with `cfg_inreg`=1, the data is `nbr_pin` and `cfg_invert` is ignored. The T setting then acts as D.
- R11: A non-buried cell ignores `cfg_inreg` and `nbr_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk | input | NUM_GCLK | Global clock levels |
| pterm | input | N_PT | Product terms feeding the sum |
| nbr_pin | input | 1 | Neighbouring pin level for the input-register use |
| cfg_mode | input | 2 | 0 combinatorial, 1 D, 2 T, 3 latch |
| cfg_invert | input | 1 | Complement the sum term |
| cfg_clk_sel | input | SEL_W | Index of the global clock used |
| cfg_pin_en | input | 1 | Drive the pin (non-buried only) |
| cfg_inreg | input | 1 | Input-register use (buried only) |
| fb_out | output | 1 | Cell output to the interconnect |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The one bit of stored state is observable on `fb_out` in every registered mode. A wrong toggle, a missed capture, or a capture from the unselected clock therefore shows at the port one system cycle after the offending edge. It stays visible until the next trigger. A stuck edge detector shows as a double toggle in T mode on the next cycle. A wrong polarity or source selection appears in the same cycle in the combinatorial and open-latch settings.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MC_COMB  = 2'd0,
    MC_DFF   = 2'd1,
    MC_TFF   = 2'd2,
    MC_LATCH = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/mc_sum_pol.sv
module mc_sum_pol #(
  parameter int N_PT   = 16,
  parameter bit BURIED = 1'b0
) (
  input  logic [N_PT-1:0] pterm,
  input  logic            invert,
  input  logic            inreg,
  input  logic            nbr_pin,
  output logic            data_o,
  output logic            from_pin_o
);
  logic sum_term;
  logic pol_term;

  always_comb begin
    sum_term   = |pterm;
    pol_term   = sum_term ^ invert;
    from_pin_o = BURIED & inreg;
    data_o     = from_pin_o ? nbr_pin : pol_term;
  end
endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int NUM_GCLK = 2,
  parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [SEL_W-1:0]    sel,
  output logic                level_o,
  output logic                rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    level_o = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (int'(sel) == i) level_o = gclk[i];
    end
    rise_o = level_o & ~prev_q;
    prev_d = level_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  p_rise_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mc_mode_e mode,
  input  logic     force_d,
  input  logic     level,
  input  logic     rise,
  input  logic     d,
  output logic     q_o
);
  mc_mode_e mode_eff;
  logic     state_q;
  logic     state_d;
  logic     state_en;

  always_comb begin
    mode_eff = (force_d && mode == MC_TFF) ? MC_DFF : mode;
    state_en = 1'b0;
    state_d  = state_q;
    case (mode_eff)
      MC_DFF: begin
        state_en = rise;
        state_d  = d;
      end
      MC_TFF: begin
        state_en = rise & d;
        state_d  = ~state_q;
      end
      MC_LATCH: begin
        state_en = level;
        state_d  = d;
      end
      default: begin
        state_en = 1'b0;
        state_d  = state_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= 1'b0;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    case (mode_eff)
      MC_COMB:  q_o = d;
      MC_LATCH: q_o = level ? d : state_q;
      default:  q_o = state_q;
    endcase
  end

  p_dff_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MC_DFF && !rise) |=> $stable(state_q));
  p_tff_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MC_TFF && rise && d) |=> (state_q != $past(state_q)));
  p_tff_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MC_TFF && !d) |=> $stable(state_q));
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MC_LATCH && !level) |=> $stable(state_q));
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int N_PT     = 16,
  parameter int NUM_GCLK = 2,
  parameter bit BURIED   = 1'b0,
  localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [N_PT-1:0]     pterm,
  input  logic                nbr_pin,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_invert,
  input  logic [SEL_W-1:0]    cfg_clk_sel,
  input  logic                cfg_pin_en,
  input  logic                cfg_inreg,
  output logic                fb_out,
  output logic                pin_out,
  output logic                pin_oe
);
  logic     data;
  logic     from_pin;
  logic     level;
  logic     rise;
  logic     cell_q;
  mc_mode_e mode;

  assign mode = mc_mode_e'(cfg_mode);

  mc_sum_pol #(.N_PT(N_PT), .BURIED(BURIED)) i_sum (
    .pterm      (pterm),
    .invert     (cfg_invert),
    .inreg      (cfg_inreg),
    .nbr_pin    (nbr_pin),
    .data_o     (data),
    .from_pin_o (from_pin)
  );

  mc_clk_pick #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) i_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gclk    (gclk),
    .sel     (cfg_clk_sel),
    .level_o (level),
    .rise_o  (rise)
  );

  mc_store i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .force_d (from_pin),
    .level   (level),
    .rise    (rise),
    .d       (data),
    .q_o     (cell_q)
  );

  assign fb_out = cell_q;

  generate
    if (BURIED) begin : g_buried
      logic pin_unused;
      assign pin_unused = cfg_pin_en;
      assign pin_oe     = 1'b0 & pin_unused;
      assign pin_out    = 1'b0;
    end else begin : g_io
      assign pin_oe  = cfg_pin_en;
      assign pin_out = cfg_pin_en & cell_q;
    end
  endgenerate

  p_comb_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MC_COMB) |-> (fb_out == data));
  p_pin_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (pin_out == fb_out));
  p_pin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
endmodule

// File: tb/test_mc_cell.sv
`timescale 1ns/1ps
module test_mc_cell;
  localparam int NPT = 16;

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     gclk = 2'b00;
  logic [NPT-1:0] pterm = '0;
  logic           nbr = 1'b0;
  logic [1:0]     c_mode = 2'd1;
  logic           c_inv = 1'b0;
  logic           c_sel = 1'b0;
  logic           c_pe = 1'b1;
  logic           c_inreg = 1'b0;
  logic           io_fb, io_pin, io_oe, b_fb, b_pin, b_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];
  logic ms_io, ms_b, m_prev;

  always #2 clk = ~clk;

  mc_cell #(.N_PT(NPT), .NUM_GCLK(2), .BURIED(1'b0)) i_mc_cell (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .pterm(pterm), .nbr_pin(nbr),
    .cfg_mode(c_mode), .cfg_invert(c_inv), .cfg_clk_sel(c_sel),
    .cfg_pin_en(c_pe), .cfg_inreg(c_inreg),
    .fb_out(io_fb), .pin_out(io_pin), .pin_oe(io_oe));

  mc_cell #(.N_PT(NPT), .NUM_GCLK(2), .BURIED(1'b1)) i_mc_cell_buried (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .pterm(pterm), .nbr_pin(nbr),
    .cfg_mode(c_mode), .cfg_invert(c_inv), .cfg_clk_sel(c_sel),
    .cfg_pin_en(c_pe), .cfg_inreg(c_inreg),
    .fb_out(b_fb), .pin_out(b_pin), .pin_oe(b_oe));

  function automatic logic cell_out(logic s, logic d, logic lvl, logic [1:0] m);
    case (m)
      2'd0:    return d;
      2'd3:    return lvl ? d : s;
      default: return s;
    endcase
  endfunction

  function automatic logic cell_next(logic s, logic d, logic lvl, logic rs, logic [1:0] m);
    case (m)
      2'd1:    return rs ? d : s;
      2'd2:    return (rs && d) ? ~s : s;
      2'd3:    return lvl ? d : s;
      default: return s;
    endcase
  endfunction

  task automatic reconfig(input logic [1:0] m, input logic inv, input logic sel,
                          input logic pe, input logic ir);
    @(negedge clk);
    rst_n = 1'b0; gclk = 2'b00; pterm = '0; nbr = 1'b0;
    c_mode = m; c_inv = inv; c_sel = sel; c_pe = pe; c_inreg = ir;
    @(negedge clk);
    rst_n = 1'b1;
    ms_io = 1'b0; ms_b = 1'b0; m_prev = 1'b0;
  endtask

  task automatic step(input logic [NPT-1:0] p, input logic [1:0] g,
                      input logic nb, input string tag);
    logic d_io, d_b, lvl, rs, o_io, o_b;
    logic [1:0] m_b;
    exp_t e;
    @(negedge clk);
    pterm = p; gclk = g; nbr = nb;
    lvl  = g[c_sel];
    rs   = lvl & ~m_prev;
    d_io = (|p) ^ c_inv;
    d_b  = c_inreg ? nb : d_io;
    m_b  = (c_inreg && c_mode == 2'd2) ? 2'd1 : c_mode;
    o_io = cell_out(ms_io, d_io, lvl, c_mode);
    o_b  = cell_out(ms_b, d_b, lvl, m_b);
    e.v   = {o_io, c_pe & o_io, c_pe, o_b, 1'b0, 1'b0};
    e.tag = tag;
    q.push_back(e);
    ms_io  = cell_next(ms_io, d_io, lvl, rs, c_mode);
    ms_b   = cell_next(ms_b, d_b, lvl, rs, m_b);
    m_prev = lvl;
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = q.pop_front();
      act = {io_fb, io_pin, io_oe, b_fb, b_pin, b_oe};
      checks++;
      if (act !== e.v) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b (io_fb,io_pin,io_oe,b_fb,b_pin,b_oe)",
                 e.tag, act, e.v);
      end
    end
  end

  localparam logic [NPT-1:0] ONE = 16'h0100;

  initial begin
    ms_io = 1'b0; ms_b = 1'b0; m_prev = 1'b0;
    // R1: reset value in D mode
    reconfig(2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    step('0, 2'b00, 1'b0, "R1 reset");
    step(ONE, 2'b00, 1'b0, "R1 no trigger yet");
    // R2 R3: combinatorial, both polarities, no/one/all terms
    reconfig(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    step('0, 2'b00, 1'b0, "R2 R3 no term");
    step(ONE, 2'b00, 1'b0, "R2 R3 one term");
    step('1, 2'b01, 1'b0, "R2 R3 all terms");
    step(16'h0001, 2'b00, 1'b0, "R3 low term");
    reconfig(2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    step('0, 2'b00, 1'b0, "R2 inverted zero");
    step(16'h8000, 2'b00, 1'b0, "R2 inverted one");
    // R4 R7: D flip-flop on clock 0
    reconfig(2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(ONE, 2'b01, 1'b0, "R4 edge capture");
    step(ONE, 2'b01, 1'b0, "R4 visible");
    step('0, 2'b01, 1'b0, "R4 high no edge");
    step('0, 2'b00, 1'b0, "R4 hold low");
    step('0, 2'b01, 1'b0, "R4 capture zero");
    step(ONE, 2'b00, 1'b0, "R4 zero visible");
    step(ONE, 2'b10, 1'b0, "R7 other clock");
    step(ONE, 2'b00, 1'b0, "R7 no capture");
    step(ONE, 2'b00, 1'b0, "R7 still held");
    // R7: clock 1 selected
    reconfig(2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    step('0, 2'b01, 1'b0, "R7 clock0 ignored");
    step('0, 2'b00, 1'b0, "R7 clock0 ignored after");
    step('0, 2'b10, 1'b0, "R7 clock1 edge");
    step('0, 2'b10, 1'b0, "R7 clock1 captured");
    // R5: toggle flip-flop
    reconfig(2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(ONE, 2'b01, 1'b0, "R5 toggle edge");
      step(ONE, 2'b00, 1'b0, "R5 toggle seen");
    end
    step('0, 2'b01, 1'b0, "R5 hold edge");
    step('0, 2'b00, 1'b0, "R5 held");
    step(ONE, 2'b11, 1'b0, "R5 toggle again");
    step(ONE, 2'b11, 1'b0, "R5 no second toggle");
    step(ONE, 2'b00, 1'b0, "R5 stable");
    // R6: latch
    reconfig(2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    step(ONE, 2'b00, 1'b0, "R6 closed");
    step(ONE, 2'b01, 1'b0, "R6 open pass one");
    step('0, 2'b01, 1'b0, "R6 open pass zero");
    step(ONE, 2'b01, 1'b0, "R6 open pass one again");
    step('0, 2'b00, 1'b0, "R6 closed hold one");
    step('0, 2'b10, 1'b0, "R6 R7 other clock closed");
    // R8: pin disabled, feedback alive
    reconfig(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(ONE, 2'b01, 1'b0, "R8 capture pin off");
    step(ONE, 2'b00, 1'b0, "R8 feedback with pin off");
    // R9 R10 R11: buried input register
    reconfig(2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
    step('0, 2'b01, 1'b1, "R10 R11 capture neighbour");
    step('0, 2'b00, 1'b0, "R10 R11 neighbour seen");
    step('0, 2'b01, 1'b0, "R10 capture low");
    step(ONE, 2'b00, 1'b1, "R9 R10 held");
    reconfig(2'd2, 1'b0, 1'b0, 1'b1, 1'b1);
    step(ONE, 2'b01, 1'b1, "R10 T acts as D");
    step(ONE, 2'b00, 1'b1, "R10 T acts as D seen");
    step(ONE, 2'b01, 1'b1, "R10 no toggle");
    step(ONE, 2'b00, 1'b1, "R10 still one");
    reconfig(2'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    step('0, 2'b01, 1'b1, "R10 latch neighbour");
    step('0, 2'b00, 1'b0, "R10 latch hold");
    reconfig(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    step('0, 2'b00, 1'b1, "R9 R11 comb neighbour");
    step(ONE, 2'b00, 1'b0, "R9 R11 comb sum");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule